// File: doc/BRIEF.md
# Dual-Clock FIFO with Standard-Mode Flags

This block is a first-in first-out buffer between two unrelated clock domains. The width defaults to 18 bits. The depth is a parameter from 256 to 4096 words, in powers of two. A producer in the write clock domain pushes words while the active-low full flag is high. A consumer in the read clock domain pulls words while the active-low empty flag is high.

The read side works in standard mode. A word is copied into a registered data output only on a read clock edge where a read is requested and the buffer holds data. At every other edge the output keeps its previous value. A separate active-low output-enable input drives a drive-enable output, which models the three-state output of a standalone part.

A three-bit strap is captured while reset is high. It selects whether the buffer runs as a single device or stays disabled. Each flag crossing goes through a two-stage synchronizer, so releasing a flag takes two or three clock edges of the observing domain.

Top module: `dcfifo_std`

## Requirements
- R1: A write takes place on a rising `wr_clk` edge where `wr_en` is 1, `full_n` is 1 and the strap enabled the buffer. The `din` value sampled on that edge is stored behind all earlier words.
- R2: On a rising `rd_clk` edge where `rd_en` is 1 and `empty_n` is 1, the oldest stored word is loaded into `dout`. On any other edge `dout` holds its value. Words leave in the order they were written, with none lost and none repeated.
- R3: `full_n` goes to 0 right after the `wr_clk` edge of the write that makes DEPTH words stored. Before that write it is 1.
- R4: `empty_n` goes to 0 right after the `rd_clk` edge of the read that takes the last stored word.
- R5: A write attempted while `full_n` is 0 is ignored. No stored word is overwritten, and after draining exactly DEPTH words come out.
- R6: A read attempted while `empty_n` is 0 is ignored. `dout` keeps its value and `empty_n` stays 0.
- R7: After the first write into an empty buffer, `empty_n` becomes 1 no earlier than the second and no later than the third rising `rd_clk` edge after the write edge.
- R8: After a read frees a location in a full buffer, `full_n` becomes 1 no earlier than the second and no later than the third rising `wr_clk` edge after the read edge.
- R9: While `rst` (active high, synchronous) is sampled high by both clocks, all stored words are discarded. After reset `empty_n` is 0, `full_n` is 1 and `dout` is 0.
- R10: `mode_strap` is captured only while `rst` is high. Codes whose bit 1 equals bit 0 (000, 011, 100, 111) enable the buffer. Any other code disables both ports: writes and reads are ignored, `empty_n` stays 0 and `full_n` stays 1. Changing the strap after reset has no effect.
- R11: `dout_drive` is 1 while `out_en_n` is 0 and 0 while `out_en_n` is 1. `dout` itself is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| mode_strap | input | 3 | Operating-mode strap captured during reset |
| wr_en | input | 1 | Write request |
| din | input | WIDTH | Write data |
| full_n | output | 1 | Low when DEPTH words are stored |
| rd_en | input | 1 | Read request |
| out_en_n | input | 1 | Active-low output drive enable |
| dout | output | WIDTH | Registered read data |
| dout_drive | output | 1 | High when the data output would be driven |
| empty_n | output | 1 | Low when no word is stored |

## Verification
The hardest situations to reach from the ports are the flag boundaries under truly independent clocks. These are the release of full after a single read, and the release of empty after a single write, each timed in edges of the other domain. Directed sequences fill the buffer to exactly DEPTH with the reader idle, push extra words while full, and then count observing-clock edges until each flag releases. Random phases with write-heavy and read-heavy enable rates, on clocks whose edges never coincide, keep the buffer bouncing on both boundaries while a scoreboard follows every accepted word.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
  localparam int WORD_W    = 18;
  localparam int MIN_DEPTH = 256;
  localparam int MAX_DEPTH = 4096;

  // Single-device operation is selected when the two low strap bits agree.
  function automatic logic strap_single(input logic [2:0] s);
    return (s[1] == s[0]);
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
  parameter int W  = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port doubles as the standard-mode output register.
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_wr_side.sv
`timescale 1ns/1ps
module dcfifo_wr_side #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    strap,
  input  logic          wr_en,
  input  logic [AW:0]   rq_gray,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_n
);
  import dcfifo_pkg::*;
  localparam int PW = AW + 1;

  logic          mode_ok;
  logic [PW-1:0] wbin, wbin_nx;

  always_ff @(posedge clk) begin
    if (rst) mode_ok <= strap_single(strap);
  end

  assign push    = wr_en & full_n & mode_ok & ~rst;
  assign wbin_nx = wbin + PW'(push);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  // Full when the write pointer is one lap ahead of the synchronized read pointer.
  assign full_n = (wgray != {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]});
  assign waddr  = wbin[AW-1:0];
endmodule

// File: rtl/dcfifo_rd_side.sv
`timescale 1ns/1ps
module dcfifo_rd_side #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    strap,
  input  logic          rd_en,
  input  logic [AW:0]   wq_gray,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty_n
);
  import dcfifo_pkg::*;
  localparam int PW = AW + 1;

  logic          mode_ok;
  logic [PW-1:0] rbin, rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) mode_ok <= strap_single(strap);
  end

  assign pop     = rd_en & empty_n & mode_ok & ~rst;
  assign rbin_nx = rbin + PW'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  assign empty_n = (rgray != wq_gray);
  assign raddr   = rbin[AW-1:0];
endmodule

// File: rtl/dcfifo_std.sv
`timescale 1ns/1ps
module dcfifo_std #(
  parameter int WIDTH       = dcfifo_pkg::WORD_W,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst,
  input  logic [2:0]       mode_strap,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  output logic             full_n,
  input  logic             rd_en,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] dout,
  output logic             dout_drive,
  output logic             empty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          push, pop;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] w_gray, r_gray, rq_gray, wq_gray;

  dcfifo_wr_side #(.AW(AW)) i_wr (
    .clk(wr_clk), .rst(rst), .strap(mode_strap), .wr_en(wr_en),
    .rq_gray(rq_gray), .push(push), .waddr(waddr), .wgray(w_gray),
    .full_n(full_n)
  );

  dcfifo_rd_side #(.AW(AW)) i_rd (
    .clk(rd_clk), .rst(rst), .strap(mode_strap), .rd_en(rd_en),
    .wq_gray(wq_gray), .pop(pop), .raddr(raddr), .rgray(r_gray),
    .empty_n(empty_n)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_r2w (
    .clk(wr_clk), .rst(rst), .d(r_gray), .q(rq_gray)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_w2r (
    .clk(rd_clk), .rst(rst), .d(w_gray), .q(wq_gray)
  );

  dcfifo_ram #(.W(WIDTH), .AW(AW)) i_ram (
    .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(din),
    .rclk(rd_clk), .rrst(rst), .re(pop), .raddr(raddr), .rdata(dout)
  );

  assign dout_drive = ~out_en_n;
endmodule

// File: rtl/dcfifo_std_chk.sv
`timescale 1ns/1ps
module dcfifo_std_chk #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256
) (
  input logic                      wr_clk,
  input logic                      rd_clk,
  input logic                      rst,
  input logic                      rd_en,
  input logic                      full_n,
  input logic                      empty_n,
  input logic [WIDTH-1:0]          dout,
  input logic [$clog2(DEPTH):0]    w_gray,
  input logic [$clog2(DEPTH):0]    r_gray,
  input logic [$clog2(DEPTH):0]    rq_gray,
  input logic [$clog2(DEPTH):0]    wq_gray
);
  localparam int PW = $clog2(DEPTH) + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (rst)
    (g2b(w_gray) - g2b(rq_gray)) <= PW'(DEPTH)); // R5

  AST_FULL_STALL: assert property (@(posedge wr_clk) disable iff (rst)
    !full_n |=> $stable(w_gray)); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rst)
    (g2b(wq_gray) - g2b(r_gray)) <= PW'(DEPTH)); // R4

  AST_EMPTY_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |=> $stable(dout)); // R6

  AST_IDLE_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_en |=> $stable(dout)); // R2

  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (rst)
    $countones(w_gray ^ $past(w_gray)) <= 1); // R1

  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (rst)
    $countones(r_gray ^ $past(r_gray)) <= 1); // R7
endmodule

bind dcfifo_std dcfifo_std_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .rd_en(rd_en),
  .full_n(full_n), .empty_n(empty_n), .dout(dout),
  .w_gray(w_gray), .r_gray(r_gray), .rq_gray(rq_gray), .wq_gray(wq_gray)
);

// File: tb/test_dcfifo_std.sv
`timescale 1ns/1ps
module test_dcfifo_std;
  localparam int W     = 18;
  localparam int DEPTH = 256;

  logic         wr_clk = 0, rd_clk = 0, rst = 1;
  logic [2:0]   mode_strap = 3'b000;
  logic         wr_en = 0, rd_en = 0, out_en_n = 0;
  logic [W-1:0] din = '0;
  logic         full_n, empty_n, dout_drive;
  logic [W-1:0] dout;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] sb [$];

  always #5 wr_clk = ~wr_clk;
  always #6.85 rd_clk = ~rd_clk;

  dcfifo_std #(.WIDTH(W), .DEPTH(DEPTH)) i_dcfifo_std (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .mode_strap(mode_strap),
    .wr_en(wr_en), .din(din), .full_n(full_n), .rd_en(rd_en),
    .out_en_n(out_en_n), .dout(dout), .dout_drive(dout_drive), .empty_n(empty_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(i * 37 + 18'h0A5);
  endfunction

  task automatic do_reset(input logic [2:0] s);
    mode_strap = s; rst = 1; wr_en = 0; rd_en = 0;
    repeat (4) @(posedge rd_clk);
    @(negedge wr_clk); rst = 0;
    @(negedge rd_clk);
    sb.delete();
  endtask

  task automatic wr1(input logic [W-1:0] d);
    @(negedge wr_clk);
    din = d; wr_en = 1;
    if (full_n) sb.push_back(d);
    @(posedge wr_clk);
    #1 wr_en = 0;
  endtask

  task automatic rd1(input string req);
    logic acc;
    logic [W-1:0] exp;
    @(negedge rd_clk);
    rd_en = 1; acc = empty_n;
    @(posedge rd_clk);
    #1 rd_en = 0;
    @(negedge rd_clk);
    if (acc) begin
      exp = sb.pop_front();
      check(dout == exp, req, 32'(dout), 32'(exp));
    end
  endtask

  task automatic rand_phase(input int n, input int wrate, input int rrate);
    int pushed = 0, popped = 0;
    fork
      begin
        while (pushed < n) begin
          @(negedge wr_clk);
          wr_en = ($urandom % 100) < wrate;
          din = W'($urandom);
          if (wr_en && full_n) begin sb.push_back(din); pushed++; end
        end
        @(negedge wr_clk) wr_en = 0;
      end
      begin
        logic pend = 0;
        logic [W-1:0] exp;
        while (popped < n) begin
          @(negedge rd_clk);
          if (pend) begin
            exp = sb.pop_front();
            check(dout == exp, "R2 random order", 32'(dout), 32'(exp)); // R1 R2
            popped++; pend = 0;
          end
          if (popped < n) begin
            rd_en = ($urandom % 100) < rrate;
            pend = rd_en && empty_n;
          end else rd_en = 0;
        end
      end
    join
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd4711));
    do_reset(3'b000);
    // R9 reset state
    check(empty_n == 0, "R9 empty after reset", 32'(empty_n), 0);
    check(full_n == 1, "R9 full after reset", 32'(full_n), 1);
    check(dout == 0, "R9 dout after reset", 32'(dout), 0);
    // R10 strap changes after reset are ignored
    mode_strap = 3'b010;
    // R11 output drive
    out_en_n = 1; #1;
    check(dout_drive == 0, "R11 drive off", 32'(dout_drive), 0);
    out_en_n = 0; #1;
    check(dout_drive == 1, "R11 drive on", 32'(dout_drive), 1);
    // R6 reads while empty
    repeat (3) rd1("R6");
    check(dout == 0, "R6 dout unchanged", 32'(dout), 0);
    check(empty_n == 0, "R6 still empty", 32'(empty_n), 0);
    // R7 empty release latency
    @(negedge wr_clk); din = pat(999); wr_en = 1; sb.push_back(din);
    @(posedge wr_clk);
    fork begin #1 wr_en = 0; end join_none
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge rd_clk); cnt++;
      @(negedge rd_clk);
      if (empty_n) break;
    end
    check(cnt >= 2 && cnt <= 3, "R7 empty release edges", 32'(cnt), 2);
    rd1("R2 first word");
    check(empty_n == 0, "R4 empty after last read", 32'(empty_n), 0);
    // R3 fill to DEPTH
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) check(full_n == 1, "R3 not full before last", 32'(full_n), 1);
      wr1(pat(i));
    end
    @(negedge wr_clk);
    check(full_n == 0, "R3 full after DEPTH writes", 32'(full_n), 0);
    // R5 writes while full
    repeat (4) wr1(18'h3FFFF);
    check(full_n == 0, "R5 still full", 32'(full_n), 0);
    // R8 full release latency
    @(negedge rd_clk); rd_en = 1;
    @(posedge rd_clk);
    fork begin #1 rd_en = 0; end join_none
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge wr_clk); cnt++;
      @(negedge wr_clk);
      if (full_n) break;
    end
    check(cnt >= 2 && cnt <= 3, "R8 full release edges", 32'(cnt), 2);
    check(dout == sb[0], "R2 read from full", 32'(dout), 32'(sb[0]));
    void'(sb.pop_front());
    while (sb.size() > 0) rd1("R5 drain order");
    @(negedge rd_clk);
    check(empty_n == 0, "R5 exactly DEPTH words", 32'(empty_n), 0);
    // R1 R2 random phases
    rand_phase(600, 50, 50);
    rand_phase(600, 90, 30);
    rand_phase(600, 30, 90);
    // R9 reset with data inside
    repeat (5) wr1(W'($urandom));
    do_reset(3'b000);
    check(empty_n == 0, "R9 empty after mid reset", 32'(empty_n), 0);
    check(full_n == 1, "R9 full after mid reset", 32'(full_n), 1);
    check(dout == 0, "R9 dout after mid reset", 32'(dout), 0);
    // R10 every strap code
    for (int s = 0; s < 8; s++) begin
      logic ok;
      ok = (s[1] == s[0]);
      do_reset(3'(s));
      wr1(pat(s + 50));
      repeat (6) @(negedge rd_clk);
      check(empty_n == ok, "R10 strap enable", 32'(empty_n), 32'(ok));
      check(full_n == 1, "R10 full flag", 32'(full_n), 1);
      if (ok) rd1("R10 strap read");
      else begin
        rd1("R10");
        check(dout == 0, "R10 read ignored", 32'(dout), 0);
      end
    end
    do_reset(3'b000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule